// File: doc/BRIEF.md
# Bidirectional SerDes mode controller

This block turns a two-pin mode code and a direction input into the enables that a bidirectional serializer/deserializer needs. It drives the enables for the serializer datapath, the deserializer datapath, the parallel-port output drivers and the serial line drivers. It also reports the selected reference-clock frequency range and the divide-by-two serial rate. The code 00 is a power-down that disables every driver and clears all internal state. The other three codes select a frequency range and leave the device running. The direction output is the direction input inverted through a purely combinational path, so a near-end device can steer a far-end one.

All control pins pass through a two-flop synchroniser and then one register stage, so a pin change reaches the enables on the third rising clock edge. A sampled copy of the reference clock goes to an activity detector, which reports activity after four toggles in a row, each no more than WINDOW system clocks after the previous one. Serialization starts on the external bit clock. The first time activity is reported, the block switches to the local reference clock and keeps that choice until the next power-down.

The state machine has three states. ST_PWRDN is entered from reset or when the synchronised code is 00. Leaving it on any nonzero code gives ST_EXTCLK, where the external bit clock is selected. ST_EXTCLK moves to ST_REFCLK when activity is detected. ST_REFCLK, with the reference clock selected, leaves only to ST_PWRDN.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: When the synchronised mode code is 00, every enable output is 0: ser_en, des_en, par_oe, ser_oe and wclk_hi. clk_src_ref, div2 and range_sel are also 0. This holds whatever the direction input is, and reset gives the same state.
- R2: dir_out equals the inverse of dir_in at all times, with no clock involved.
- R3: With a nonzero code and direction 1 (serialize), ser_en, ser_oe and wclk_hi are 1, and des_en and par_oe are 0. ser_en also serves as the enable for parallel input capture.
- R4: With a nonzero code and direction 0 (deserialize), des_en and par_oe are 1, and ser_en and wclk_hi are 0. Parallel input capture is therefore gated off.
- R5: range_sel reports the code, 01, 10 or 11. div2 is 1 only for code 11.
- R6: After power-down is left, clk_src_ref stays 0 until four consecutive toggles of refclk_in are seen, each within WINDOW clocks (default 16) of the previous one. It then becomes 1.
- R7: Once clk_src_ref is 1, it stays 1 when refclk_in stops or the direction changes. Only code 00 clears it.
- R8: In deserialize mode, ser_oe (the serial clock driver) is 1 only when clk_src_ref is 1.
- R9: A change on mode_sel or dir_in shows on the enable outputs at the third rising clock edge after the change, and not before.
- R10: A gap of WINDOW clocks or more with no toggle discards the toggles already counted, so toggles spaced 20 clocks apart never set clk_src_ref.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode code: 00 power-down, 01/10/11 frequency range, 11 also divide-by-two |
| dir_in | input | 1 | Direction: 1 serialize, 0 deserialize |
| refclk_in | input | 1 | Sampled level of the local reference clock |
| dir_out | output | 1 | Combinational inverse of dir_in |
| ser_en | output | 1 | Serializer datapath and parallel capture enable |
| des_en | output | 1 | Deserializer datapath enable |
| par_oe | output | 1 | Parallel-port output driver enable |
| ser_oe | output | 1 | Serial line driver enable |
| wclk_hi | output | 1 | Forces the word clock output high |
| clk_src_ref | output | 1 | 1 = reference clock, 0 = external bit clock |
| div2 | output | 1 | Divide-by-two serial rate selected |
| range_sel | output | 2 | Active frequency range code |

## Verification
The reference clock is driven in three ways. Toggles spaced 20 clocks apart must never latch the source. Toggles spaced 3 clocks apart must latch it. A stopped clock after the latch shows that the choice is held. Each mode code is tried with both directions. This separates the direction-driven enables from the range and divide-by-two reporting, and shows whether the serial driver depends on the latched source when deserializing. A direction change is checked edge by edge to pin the three-edge latency. A pass through power-down in the middle of the run shows that it clears the latch.

// File: rtl/serdes_mode_pkg.sv
package serdes_mode_pkg;
    typedef enum logic [1:0] {
        ST_PWRDN  = 2'd0,
        ST_EXTCLK = 2'd1,
        ST_REFCLK = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/refclk_act_det.sv
module refclk_act_det #(
    parameter int WINDOW  = 16,
    parameter int TOGGLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_lvl,
    output logic act
);
    localparam int GW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int CW = $clog2(TOGGLES + 1);

    logic          ref_d;
    logic          tog;
    logic [GW-1:0] gap;
    logic [CW-1:0] cnt;

    assign tog = ref_lvl ^ ref_d;
    assign act = tog && (cnt == CW'(TOGGLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            gap   <= '0;
            cnt   <= '0;
        end else begin
            ref_d <= ref_lvl;
            if (clr) begin
                gap <= '0;
                cnt <= '0;
            end else if (tog) begin
                gap <= '0;
                if (cnt < CW'(TOGGLES)) cnt <= cnt + 1'b1;
            end else if (gap == GW'(WINDOW - 1)) begin
                gap <= '0;
                cnt <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R10: the toggle count never runs past its saturation value
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TOGGLES));

    // R10: a full silent window discards the toggles already counted
    assert_gap_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tog && gap == GW'(WINDOW - 1)) |=> (cnt == '0));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import serdes_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_s,
    input  logic       dir_s,
    input  logic       act,
    output logic       clr_det,
    output logic       ser_en,
    output logic       des_en,
    output logic       par_oe,
    output logic       ser_oe,
    output logic       wclk_hi,
    output logic       clk_src_ref,
    output logic       div2,
    output logic [1:0] range_sel
);
    ctl_state_t state, state_nx;
    logic [1:0] mode_q;
    logic       dir_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRDN:  if (mode_s != 2'b00) state_nx = ST_EXTCLK;
            ST_EXTCLK: if (mode_s == 2'b00) state_nx = ST_PWRDN;
                       else if (act)        state_nx = ST_REFCLK;
            ST_REFCLK: if (mode_s == 2'b00) state_nx = ST_PWRDN;
            default:   state_nx = ST_PWRDN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_PWRDN;
            mode_q <= 2'b00;
            dir_q  <= 1'b0;
        end else begin
            state  <= state_nx;
            mode_q <= mode_s;
            dir_q  <= dir_s;
        end
    end

    always_comb begin
        clr_det     = 1'b0;
        ser_en      = 1'b0;
        des_en      = 1'b0;
        par_oe      = 1'b0;
        ser_oe      = 1'b0;
        wclk_hi     = 1'b0;
        clk_src_ref = 1'b0;
        div2        = 1'b0;
        range_sel   = 2'b00;
        unique case (state)
            ST_PWRDN: clr_det = 1'b1;
            ST_EXTCLK, ST_REFCLK: begin
                clk_src_ref = (state == ST_REFCLK);
                range_sel   = mode_q;
                div2        = (mode_q == 2'b11);
                ser_en      = dir_q;
                wclk_hi     = dir_q;
                des_en      = !dir_q;
                par_oe      = !dir_q;
                ser_oe      = dir_q || (state == ST_REFCLK);
            end
            default: clr_det = 1'b1;
        endcase
    end

    // R1: power-down releases every driver
    assert_pwrdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |-> !(ser_en || des_en || par_oe || ser_oe || clk_src_ref || div2));

    // R4: parallel drivers and serializer capture are never both on
    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_oe && ser_en));

    // R7: the reference-clock choice holds until a power-down code arrives
    assert_sticky_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src_ref && mode_s != 2'b00) |=> clk_src_ref);

    // R6: the reference clock is chosen only on detected activity
    assert_src_needs_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_src_ref) |-> $past(act));

    // R5: divide-by-two only while running
    assert_div2_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div2 |-> (range_sel == 2'b11));
endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl #(
    parameter int WINDOW  = 16,
    parameter int TOGGLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       dir_in,
    input  logic       refclk_in,
    output logic       dir_out,
    output logic       ser_en,
    output logic       des_en,
    output logic       par_oe,
    output logic       ser_oe,
    output logic       wclk_hi,
    output logic       clk_src_ref,
    output logic       div2,
    output logic [1:0] range_sel
);
    logic [2:0] ctl_s;
    logic       ref_s;
    logic       act;
    logic       clr_det;

    assign dir_out = !dir_in;

    sync2 #(.W(3)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({mode_sel, dir_in}), .q(ctl_s)
    );

    sync2 #(.W(1)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .d(refclk_in), .q(ref_s)
    );

    refclk_act_det #(.WINDOW(WINDOW), .TOGGLES(TOGGLES)) u_det (
        .clk(clk), .rst_n(rst_n), .clr(clr_det), .ref_lvl(ref_s), .act(act)
    );

    mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_s(ctl_s[2:1]), .dir_s(ctl_s[0]),
        .act(act), .clr_det(clr_det), .ser_en(ser_en), .des_en(des_en),
        .par_oe(par_oe), .ser_oe(ser_oe), .wclk_hi(wclk_hi),
        .clk_src_ref(clk_src_ref), .div2(div2), .range_sel(range_sel)
    );

    // R2: the direction output is the inverse of the input at every edge
    assert_dir_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out != dir_in);
endmodule

// File: tb/serdes_mode_ctrl_tb.sv
module serdes_mode_ctrl_tb;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       dir_in = 1'b0;
    logic       refclk_in = 1'b0;
    logic       dir_out, ser_en, des_en, par_oe, ser_oe, wclk_hi, clk_src_ref, div2;
    logic [1:0] range_sel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    serdes_mode_ctrl #(.WINDOW(W), .TOGGLES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_in(dir_in),
        .refclk_in(refclk_in), .dir_out(dir_out), .ser_en(ser_en),
        .des_en(des_en), .par_oe(par_oe), .ser_oe(ser_oe), .wclk_hi(wclk_hi),
        .clk_src_ref(clk_src_ref), .div2(div2), .range_sel(range_sel)
    );

    always #5 clk = !clk;

    // behavioural reference: pipeline ages of inputs and the latch rule
    int m1, m2, mq, st, cnt, gap;
    bit d1, d2, dq, r1, r2, r3;

    always @(posedge clk) begin
        bit tog, act;
        int st_n;
        if (!rst_n) begin
            m1 = 0; m2 = 0; mq = 0; st = 0; cnt = 0; gap = 0;
            d1 = 0; d2 = 0; dq = 0; r1 = 0; r2 = 0; r3 = 0;
        end else begin
            tog = (r2 != r3);
            act = tog && (cnt == 3);
            st_n = st;
            if (m2 == 0) st_n = 0;
            else if (st == 0) st_n = 1;
            else if (st == 1 && act) st_n = 2;
            if (st == 0) begin cnt = 0; gap = 0; end
            else if (tog) begin gap = 0; if (cnt < 4) cnt++; end
            else if (gap == W - 1) begin gap = 0; cnt = 0; end
            else gap++;
            st = st_n;
            mq = m2; m2 = m1; m1 = int'(mode_sel);
            dq = d2; d2 = d1; d1 = dir_in;
            r3 = r2; r2 = r1; r1 = refclk_in;
        end
    end

    task automatic chk(input string tag, input logic [1:0] act_v, input logic [1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cycles, act_v, exp_v);
        end
    endtask

    // compare every output with the model on every falling edge
    always @(negedge clk) begin
        bit on;
        if (rst_n && !done) begin
            on = (st != 0);
            chk("R1/R3/R4 ser_en",  {1'b0, ser_en},  {1'b0, on && dq});
            chk("R1/R4 des_en",     {1'b0, des_en},  {1'b0, on && !dq});
            chk("R1/R4 par_oe",     {1'b0, par_oe},  {1'b0, on && !dq});
            chk("R3/R8 ser_oe",     {1'b0, ser_oe},  {1'b0, on && (dq || st == 2)});
            chk("R3 wclk_hi",       {1'b0, wclk_hi}, {1'b0, on && dq});
            chk("R6/R7 clk_src_ref",{1'b0, clk_src_ref}, {1'b0, st == 2});
            chk("R5 div2",          {1'b0, div2},    {1'b0, on && mq == 3});
            chk("R5 range_sel",     range_sel,       on ? 2'(mq) : 2'b00);
            chk("R2 dir_out",       {1'b0, dir_out}, {1'b0, !dir_in});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggles(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            refclk_in = !refclk_in;
            cyc(spacing);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 reset ser_en", {1'b0, ser_en}, 2'b00);
        chk("R1 reset par_oe", {1'b0, par_oe}, 2'b00);
        rst_n = 1'b1;
        cyc(2);
        // R1: direction ignored in power-down
        dir_in = 1'b1; cyc(5);
        chk("R1 pd dir1 ser_en", {1'b0, ser_en}, 2'b00);
        chk("R1 pd dir1 ser_oe", {1'b0, ser_oe}, 2'b00);
        // R2: combinational inversion
        dir_in = 1'b0; #1; chk("R2 dir_out comb", {1'b0, dir_out}, 2'b01);
        dir_in = 1'b1; #1; chk("R2 dir_out comb", {1'b0, dir_out}, 2'b00);
        cyc(1);
        // R3: serializer in range 01
        mode_sel = 2'b01; cyc(5);
        chk("R3 ser_en", {1'b0, ser_en}, 2'b01);
        chk("R3 wclk_hi", {1'b0, wclk_hi}, 2'b01);
        chk("R6 ext clock first", {1'b0, clk_src_ref}, 2'b00);
        // R10: slow toggles never latch
        toggles(6, 20);
        chk("R10 slow toggles", {1'b0, clk_src_ref}, 2'b00);
        // R6: fast toggles latch
        toggles(6, 3); cyc(4);
        chk("R6 latched", {1'b0, clk_src_ref}, 2'b01);
        // R7: clock stops, direction flips
        cyc(50);
        chk("R7 held after stop", {1'b0, clk_src_ref}, 2'b01);
        // R9: latency of a direction change
        dir_in = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        chk("R9 before third edge", {1'b0, ser_en}, 2'b01);
        @(posedge clk); #2;
        chk("R9 at third edge", {1'b0, ser_en}, 2'b00);
        cyc(2);
        // R4/R8: deserializer with latched reference clock
        chk("R4 des_en", {1'b0, des_en}, 2'b01);
        chk("R4 par_oe", {1'b0, par_oe}, 2'b01);
        chk("R8 ser_oe ref", {1'b0, ser_oe}, 2'b01);
        chk("R7 held after dir", {1'b0, clk_src_ref}, 2'b01);
        // R5: ranges
        mode_sel = 2'b11; cyc(5);
        chk("R5 div2 on 11", {1'b0, div2}, 2'b01);
        chk("R5 range 11", range_sel, 2'b11);
        mode_sel = 2'b10; cyc(5);
        chk("R5 div2 off 10", {1'b0, div2}, 2'b00);
        chk("R5 range 10", range_sel, 2'b10);
        // R1/R7: power-down clears the latch
        mode_sel = 2'b00; cyc(5);
        chk("R1 pd des_en", {1'b0, des_en}, 2'b00);
        chk("R7 cleared by pd", {1'b0, clk_src_ref}, 2'b00);
        // R8: deserializer without reference clock
        mode_sel = 2'b10; cyc(6);
        chk("R8 ser_oe ext", {1'b0, ser_oe}, 2'b00);
        dir_in = 1'b1; cyc(5);
        chk("R3 ser_oe", {1'b0, ser_oe}, 2'b01);
        toggles(5, 2); cyc(4);
        chk("R6 relatch", {1'b0, clk_src_ref}, 2'b01);
        cyc(3);
        done = 1;
        summary();
    end
endmodule